// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Slave Port

This block is the slave port for an 8-bit bus on which address and data share the same lines. It sits in front of a 128-byte map of clock registers and RAM. On each cycle it captures a 7-bit location from the shared lines. It then serves a read by driving the map's byte back onto the lines, or serves a write by handing a byte and a per-bit write mask to the map. A static mode input selects how the strobes are read. In one mode a data strobe is qualified by a read/write level. In the other mode there are separate active-low read and write lines.

All bus inputs are oversampled by a fast system clock through a two-flop synchronizer, and every edge is detected in that clock domain. The block protects the read-only parts of the map through the write mask. It also gives the status logic a one-cycle pulse after each completed read of the interrupt status byte, so that the flags can be cleared there. A power-fail or reset input blocks every access.

Top module: `mux_bus_if`

## Requirements
- R1: A falling edge of `as_i` loads `ad_i[6:0]` into `mem_addr_o`; `ad_i[7]` is dropped. The load happens whether or not `cs_ni` is low, and it is visible within 4 clock cycles.
- R2: With `mode_moto_i`=1, a read is `ds_i` high with `rw_i` high and `cs_ni` low. While it lasts, `ad_oe_o`=1 and `ad_o`=`mem_rdata_i`. Both return to 0 after `ds_i` falls.
- R3: With `mode_moto_i`=1, a write is `ds_i` high with `rw_i` low. After `ds_i` falls, `mem_we_o` pulses for exactly one cycle, carrying the byte that was on `ad_i` before the trailing edge.
- R4: With `mode_moto_i`=0, `ds_i` is an active-low read line. While it is low with `cs_ni` low, `ad_oe_o`=1 and `ad_o`=`mem_rdata_i`. The bus is released after `ds_i` rises.
- R5: With `mode_moto_i`=0, `rw_i` is an active-low write line. Its rising edge commits one `mem_we_o` pulse with the byte that was held on `ad_i`.
- R6: A strobe counts only if `cs_ni` stays low for its whole length. If `cs_ni` rises at any point during the strobe, no write pulse and no read pulse follow.
- R7: Write mask by location: 0x0C and 0x0D are fully read-only, so no `mem_we_o` is issued for them. Locations 0x00 and 0x0A get mask 0x7F (bit 7 protected). Every other location gets mask 0xFF.
- R8: While `inhibit_i`=1, no location is latched, no write is issued, and `ad_oe_o` is 0 from the next cycle on.
- R9: `rd_c_o` pulses for one cycle after a completed read of location 0x0C, and for no other location.
- R10: After reset, `ad_oe_o`, `mem_we_o` and `rd_c_o` are 0 and `mem_addr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bus strobes |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_moto_i | input | 1 | 1: data strobe plus R/W level; 0: separate read/write lines |
| inhibit_i | input | 1 | Power-fail or reset active; blocks all access |
| cs_ni | input | 1 | Active-low chip select |
| as_i | input | 1 | Address strobe; location captured on its falling edge |
| ds_i | input | 1 | Data strobe (mode 1) or active-low read (mode 0) |
| rw_i | input | 1 | Read-high/write-low (mode 1) or active-low write (mode 0) |
| ad_i | input | 8 | Shared address/data lines, input side |
| ad_o | output | 8 | Read data, output side |
| ad_oe_o | output | 1 | Output enable for `ad_o` |
| mem_addr_o | output | 7 | Latched map location |
| mem_rdata_i | input | 8 | Byte read from the map at `mem_addr_o` |
| mem_we_o | output | 1 | One-cycle write strobe to the map |
| mem_wdata_o | output | 8 | Write byte |
| mem_wmask_o | output | 8 | Bits of the byte that may change |
| rd_c_o | output | 1 | One-cycle pulse after a completed read of 0x0C |

## Verification
The bench runs the same read and write table through both strobe modes. This exposes a decoder that swaps the meaning of `ds_i` and `rw_i` between modes, which would drive the bus during writes or miss commits. The protected locations are each written, so that a wrong mask either corrupts bit 7 of 0x00 or 0x0A, or emits a write strobe for 0x0C or 0x0D. Directed cases cover three more faults. If the address latch were gated by chip select, a cycle without select would leave the old location. If chip select were sampled only at the strobe edges, a select that drops in mid-strobe would still commit the write. If inhibit were ignored, data would be written during power fail. A read of 0x0D and a read of 0x0C reached through an address with bit 7 set check that the status pulse follows only the true location.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] LOC_SEC  = 7'h00;
  localparam logic [ADDR_W-1:0] LOC_CTLA = 7'h0A;
  localparam logic [ADDR_W-1:0] LOC_STAT = 7'h0C;
  localparam logic [ADDR_W-1:0] LOC_VALD = 7'h0D;

  function automatic logic [DATA_W-1:0] wr_mask(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] m;
    m = '1;
    if (a == LOC_STAT || a == LOC_VALD) m = '0;
    else if (a == LOC_SEC || a == LOC_CTLA) m[DATA_W-1] = 1'b0;
    return m;
  endfunction
endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= d_i[i];
        s2 <= s1;
      end
    end
    assign q_o[i] = s2;
  end
endmodule

// File: rtl/mbus_strobe_track.sv
module mbus_strobe_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic sel_i,
  output logic ok_o,
  output logic done_o
);
  logic act_q, ok_q;

  // ok holds only while select was valid since the strobe's leading edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      ok_q  <= 1'b0;
    end else begin
      act_q <= act_i;
      ok_q  <= act_i & sel_i & (ok_q | ~act_q);
    end
  end

  assign ok_o   = ok_q;
  assign done_o = act_q & ~act_i & ok_q;
endmodule

// File: rtl/mux_bus_if.sv
module mux_bus_if
  import mbus_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_moto_i,
  input  logic              inhibit_i,
  input  logic              cs_ni,
  input  logic              as_i,
  input  logic              ds_i,
  input  logic              rw_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [DATA_W-1:0] mem_wmask_o,
  output logic              rd_c_o
);
  localparam int SW = DATA_W + 4;
  localparam logic [SW-1:0] SYNC_RST = SW'(1) << 3; // cs_n idles high
  localparam int N_STB = 2; // 0: read, 1: write

  logic [SW-1:0] raw, syn;
  assign raw = {ad_i, cs_ni, rw_i, ds_i, as_i};

  mbus_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  logic              as_s, ds_s, rw_s, cs_s, as_q;
  logic [DATA_W-1:0] ad_s, ad_q;
  assign as_s = syn[0];
  assign ds_s = syn[1];
  assign rw_s = syn[2];
  assign cs_s = syn[3];
  assign ad_s = syn[SW-1:4];

  logic sel;
  assign sel = ~cs_s & ~inhibit_i;

  logic [N_STB-1:0] act, ok, done;
  assign act[0] = mode_moto_i ? (ds_s & rw_s)  : ~ds_s;
  assign act[1] = mode_moto_i ? (ds_s & ~rw_s) : ~rw_s;

  for (genvar k = 0; k < N_STB; k++) begin : g_stb
    mbus_strobe_track u_trk (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .act_i (act[k]),
      .sel_i (sel),
      .ok_o  (ok[k]),
      .done_o(done[k])
    );
  end

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] mask;
  assign mask = wr_mask(addr_q);

  logic              we_q, rdc_q;
  logic [DATA_W-1:0] wd_q, wm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      as_q   <= 1'b0;
      ad_q   <= '0;
      addr_q <= '0;
      we_q   <= 1'b0;
      wd_q   <= '0;
      wm_q   <= '0;
      rdc_q  <= 1'b0;
    end else begin
      as_q  <= as_s;
      ad_q  <= ad_s;
      if (as_q && !as_s && !inhibit_i) addr_q <= ad_s[ADDR_W-1:0];
      we_q  <= done[1] & (|mask);
      if (done[1]) begin
        wd_q <= ad_q; // byte seen while strobe was still active
        wm_q <= mask;
      end
      rdc_q <= done[0] & (addr_q == LOC_STAT);
    end
  end

  assign ad_oe_o     = ok[0];
  assign ad_o        = ok[0] ? mem_rdata_i : '0;
  assign mem_addr_o  = addr_q;
  assign mem_we_o    = we_q;
  assign mem_wdata_o = wd_q;
  assign mem_wmask_o = wm_q;
  assign rd_c_o      = rdc_q;

  a_r8_inhibit_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(inhibit_i) |-> !ad_oe_o);
  a_r7_we_mask_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_wmask_o != '0));
  a_r3_we_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);
  a_r9_rdc_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_c_o |=> !rd_c_o);
  a_r9_rdc_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_c_o |-> $past(ad_oe_o));
endmodule

// File: tb/sim_mux_bus_if.sv
module sim_mux_bus_if;
  logic       clk = 0, rst_ni = 0;
  logic       mode_moto = 1, inhibit = 0, cs_n = 1, as_s = 0, ds = 0, rw = 1;
  logic [7:0] ad = 0, rdata = 0;
  logic [7:0] ad_o, wdata, wmask;
  logic       ad_oe, we, rdc;
  logic [6:0] maddr;

  always #2.5 clk = ~clk;

  mux_bus_if u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mode_moto_i(mode_moto), .inhibit_i(inhibit),
    .cs_ni(cs_n), .as_i(as_s), .ds_i(ds), .rw_i(rw), .ad_i(ad), .ad_o(ad_o),
    .ad_oe_o(ad_oe), .mem_addr_o(maddr), .mem_rdata_i(rdata), .mem_we_o(we),
    .mem_wdata_o(wdata), .mem_wmask_o(wmask), .rd_c_o(rdc)
  );

  int total = 0, bad = 0;
  int we_cnt = 0, rdc_cnt = 0;
  logic [7:0] l_wd, l_wm;
  logic [6:0] l_wa;

  always @(negedge clk) begin
    if (we) begin we_cnt++; l_wd = wdata; l_wm = wmask; l_wa = maddr; end
    if (rdc) rdc_cnt++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s act=%0h exp=%0h", tag, act, exp); end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_mode(input bit m);
    cs_n = 1; mode_moto = m; ds = m ? 1'b0 : 1'b1; rw = 1; step(6);
  endtask

  task automatic latch(input logic [7:0] a);
    ad = a; as_s = 1; step(4); as_s = 0; step(4);
  endtask

  // mode, wr, addr[6:0], data, exp_mask
  localparam int NV = 10;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 1'b1, 7'h10, 8'hA5, 8'hFF},
    {1'b1, 1'b0, 7'h10, 8'h3C, 8'hFF},
    {1'b0, 1'b1, 7'h20, 8'h5A, 8'hFF},
    {1'b0, 1'b0, 7'h7F, 8'hC3, 8'hFF},
    {1'b1, 1'b1, 7'h00, 8'hFF, 8'h7F},
    {1'b0, 1'b1, 7'h0A, 8'h80, 8'h7F},
    {1'b1, 1'b1, 7'h0C, 8'h11, 8'h00},
    {1'b0, 1'b1, 7'h0D, 8'h22, 8'h00},
    {1'b1, 1'b0, 7'h0C, 8'h96, 8'hFF},
    {1'b0, 1'b0, 7'h0D, 8'h69, 8'hFF}
  };

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    // R10 reset state
    chk(!ad_oe && !we && !rdc && maddr == 0, "R10 reset", {ad_oe, we, rdc, maddr}, 0);
    rst_ni = 1; step(6);

    for (int i = 0; i < NV; i++) begin
      logic m, w; logic [6:0] a; logic [7:0] d, msk; int w0, r0;
      {m, w, a, d, msk} = VEC[i];
      set_mode(m);
      latch({1'b0, a});
      chk(maddr == a, "R1 addr", maddr, a);
      w0 = we_cnt; r0 = rdc_cnt;
      cs_n = 0; ad = d; rdata = d; step(2);
      if (w) begin
        if (m) begin rw = 0; step(2); ds = 1; step(6); ds = 0; step(6); rw = 1; end
        else   begin rw = 0; step(6); rw = 1; step(6); end
        if (msk != 0) begin
          chk(we_cnt == w0 + 1, m ? "R3 we" : "R5 we", we_cnt - w0, 1);
          chk(l_wd == d && l_wa == a, m ? "R3 data" : "R5 data", l_wd, d);
          chk(l_wm == msk, "R7 mask", l_wm, msk);
        end else
          chk(we_cnt == w0, "R7 ro no we", we_cnt - w0, 0);
      end else begin
        if (m) ds = 1; else ds = 0;
        step(6);
        chk(ad_oe && ad_o == d, m ? "R2 drive" : "R4 drive", ad_o, d);
        ds = m ? 1'b0 : 1'b1;
        step(6);
        chk(!ad_oe, m ? "R2 release" : "R4 release", ad_oe, 0);
        chk(rdc_cnt == r0 + ((a == 7'h0C) ? 1 : 0), "R9 rd_c", rdc_cnt - r0, (a == 7'h0C));
      end
      cs_n = 1; step(2);
    end

    // R1: bit 7 dropped, then R9 read of 0x0C
    begin
      int r0;
      set_mode(1);
      latch(8'h8C);
      chk(maddr == 7'h0C, "R1 bit7", maddr, 7'h0C);
      r0 = rdc_cnt;
      cs_n = 0; rdata = 8'h44; step(2); ds = 1; step(6); ds = 0; step(6); cs_n = 1;
      chk(rdc_cnt == r0 + 1, "R9 rd_c 0C", rdc_cnt - r0, 1);
    end

    // R1: address latched without chip select; no access
    begin
      int w0;
      latch(8'h33);
      chk(maddr == 7'h33, "R1 no cs latch", maddr, 7'h33);
      w0 = we_cnt;
      rw = 0; ad = 8'h77; step(2); ds = 1; step(6);
      chk(!ad_oe, "R6 no cs drive", ad_oe, 0);
      ds = 0; step(6); rw = 1;
      chk(we_cnt == w0, "R6 no cs write", we_cnt - w0, 0);
    end

    // R6: select drops mid-strobe
    begin
      int w0;
      w0 = we_cnt;
      cs_n = 0; rw = 0; step(2); ds = 1; step(4); cs_n = 1; step(3); cs_n = 0; step(3);
      ds = 0; step(6); rw = 1; cs_n = 1; step(2);
      chk(we_cnt == w0, "R6 mid drop", we_cnt - w0, 0);
    end

    // R8: inhibit blocks latch, write, and read drive
    begin
      int w0;
      set_mode(0);
      inhibit = 1;
      latch(8'h55);
      chk(maddr == 7'h33, "R8 no latch", maddr, 7'h33);
      w0 = we_cnt;
      cs_n = 0; rw = 0; step(6); rw = 1; step(6);
      chk(we_cnt == w0, "R8 no write", we_cnt - w0, 0);
      ds = 0; step(6);
      chk(!ad_oe, "R8 no drive", ad_oe, 0);
      ds = 1; step(4); cs_n = 1;
      inhibit = 0; step(4);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule